// File: doc/BRIEF.md
# USB Transfer Status and Interrupt Unit

This unit sits beside the transaction engine of a frame-scheduled USB host controller. For each transaction the engine hands it the control and status fields of the current transfer descriptor (active bit, completion-interrupt request, short-packet request and a 2-bit error counter), together with the transaction outcome, a short-packet indication and the transferred length. One cycle later the unit returns the updated descriptor status fields that the engine writes back.

Interrupt causes seen during a frame are held in a pending set and are moved into the host status register only on the end-of-frame strobe. Software reads the two status bits, clears them by writing ones, and programs an interrupt enable register. A single level interrupt request is the OR of each latched cause ANDed with its enable. Stall-type failures always raise it.

Top module: `usb_xfer_status_unit`

## Requirements
- R1: After reset, `sts_o`, `ien_o`, `irq_o` and `upd_valid_o` are all 0.
- R2: `outcome_i` codes are 0 ACK, 1 NAK, 2 STALL, 3 BABBLE, 4 CRC/timeout, 5 buffer overrun/underrun, and 6 and 7 are unused. On ACK of an active descriptor, the updated active bit is 0, the length field holds `xfer_len_i` and the error counter is unchanged. Each update appears on the `upd_*` outputs with `upd_valid_o` one cycle after `td_valid_i`, and the length field is 0 for every outcome other than ACK.
- R3: NAK, the unused codes 6 and 7, and any outcome for a descriptor whose active bit is 0 leave the active bit and the error counter unchanged, with no stalled or babble bit. On their own they set no status bit.
- R4: STALL sets stalled, clears active and leaves the error counter unchanged.
- R5: BABBLE sets both stalled and babble, clears active and leaves the error counter unchanged.
- R6: CRC/timeout and buffer errors decrement a nonzero error counter. When the counter goes from 1 to 0, active is cleared and stalled is set. A counter of 0 is left at 0 and the descriptor stays active.
- R7: A descriptor with the completion-interrupt flag whose updated active bit is 0 sets `sts_o[0]`, but only at the next end-of-frame strobe. This includes a descriptor that was already inactive when read.
- R8: If such a completion also ended stalled, `sts_o[1]` is set at the same frame end.
- R9: An ACK with `short_pkt_i` and the short-packet flag set sets `sts_o[0]` at frame end. It drives `irq_o` only when `ien_o[3]` is 1. A short packet without the flag sets nothing.
- R10: A CRC/timeout outcome sets `sts_o[1]` at frame end. It drives `irq_o` only when `ien_o[0]` is 1.
- R11: A stalled result (STALL, BABBLE or an exhausted counter) sets `sts_o[1]` at frame end and drives `irq_o` whatever the enables are.
- R12: A completion interrupt drives `irq_o` only while `ien_o[2]` is 1.
- R13: Writing 1 to a bit of `sts_clr_i` under `sts_clr_we_i` clears that status bit and its interrupt causes, and `irq_o` stays high until then. A set at frame end takes priority over a clear in the same cycle.
- R14: A cause presented in the same cycle as `eof_i` takes effect at that frame end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| td_valid_i | input | 1 | Transaction result present this cycle |
| td_active_i | input | 1 | Descriptor active bit as read |
| td_ioc_i | input | 1 | Descriptor completion-interrupt flag |
| td_spd_i | input | 1 | Descriptor short-packet flag |
| td_cerr_i | input | CERR_W | Descriptor error counter as read |
| outcome_i | input | 3 | Transaction outcome code |
| short_pkt_i | input | 1 | Received packet shorter than the endpoint maximum |
| xfer_len_i | input | LEN_W | Bytes actually transferred |
| eof_i | input | 1 | End-of-frame strobe |
| sts_clr_we_i | input | 1 | Status clear write strobe |
| sts_clr_i | input | 2 | Write-1-to-clear mask for the status bits |
| ien_we_i | input | 1 | Enable register write strobe |
| ien_i | input | 4 | Enable value: bit0 CRC/timeout, bit2 completion, bit3 short packet |
| upd_valid_o | output | 1 | Updated descriptor fields valid |
| upd_active_o | output | 1 | Updated active bit |
| upd_stalled_o | output | 1 | Updated stalled bit |
| upd_babble_o | output | 1 | Updated babble bit |
| upd_crcto_o | output | 1 | CRC/timeout seen on this transaction |
| upd_buferr_o | output | 1 | Buffer error seen on this transaction |
| upd_cerr_o | output | CERR_W | Updated error counter |
| upd_len_o | output | LEN_W | Recorded transfer length |
| sts_o | output | 2 | Status: bit0 USB interrupt, bit1 USB error |
| ien_o | output | 4 | Enable register contents |
| irq_o | output | 1 | Interrupt request level |

## Verification
A lost or stale pending cause first shows up at the first end-of-frame strobe after the transaction. At that strobe a status bit fails to rise, or rises one frame late, so every status check is placed directly after a strobe and also once before it. A wrong latched cause shows up when the enable register changes and `irq_o` does not follow it, or stays high after the status bit has been cleared. A wrong counter or stall decision shows up on the `upd_*` fields exactly one cycle after the transaction, and the scoreboard compares them there.

// File: rtl/usbst_pkg.sv
package usbst_pkg;

    typedef enum logic [2:0] {
        OUT_ACK    = 3'd0,
        OUT_NAK    = 3'd1,
        OUT_STALL  = 3'd2,
        OUT_BABBLE = 3'd3,
        OUT_CRCTO  = 3'd4,
        OUT_BUFERR = 3'd5
    } outcome_e;

    // one bit per interrupt cause, collected per frame
    typedef struct packed {
        logic ioc;
        logic spd;
        logic crcto;
        logic fatal;
    } cause_t;

    localparam int NCAUSE = $bits(cause_t);
    localparam int STS_W  = 2;
    localparam int IEN_W  = 4;

endpackage

// File: rtl/usbst_td_update.sv
module usbst_td_update
    import usbst_pkg::*;
#(
    parameter int LEN_W  = 11,
    parameter int CERR_W = 2
) (
    input  logic              valid_i,
    input  logic              active_i,
    input  logic              ioc_i,
    input  logic              spd_i,
    input  logic [CERR_W-1:0] cerr_i,
    input  logic [2:0]        outcome_i,
    input  logic              short_i,
    input  logic [LEN_W-1:0]  len_i,
    output logic              active_o,
    output logic              stalled_o,
    output logic              babble_o,
    output logic              crcto_o,
    output logic              buferr_o,
    output logic [CERR_W-1:0] cerr_o,
    output logic [LEN_W-1:0]  len_o,
    output cause_t            cause_o
);

    localparam logic [CERR_W-1:0] CERR_ONE = CERR_W'(1);

    logic count_err;

    always_comb begin
        active_o  = active_i;
        stalled_o = 1'b0;
        babble_o  = 1'b0;
        crcto_o   = 1'b0;
        buferr_o  = 1'b0;
        cerr_o    = cerr_i;
        len_o     = '0;
        count_err = 1'b0;
        if (active_i) begin
            case (outcome_i)
                OUT_ACK: begin
                    active_o = 1'b0;
                    len_o    = len_i;
                end
                OUT_STALL: begin
                    active_o  = 1'b0;
                    stalled_o = 1'b1;
                end
                OUT_BABBLE: begin
                    active_o  = 1'b0;
                    stalled_o = 1'b1;
                    babble_o  = 1'b1;
                end
                OUT_CRCTO: begin
                    crcto_o   = 1'b1;
                    count_err = 1'b1;
                end
                OUT_BUFERR: begin
                    buferr_o  = 1'b1;
                    count_err = 1'b1;
                end
                default: ;
            endcase
            // zero means unlimited retries: never decremented
            if (count_err && (cerr_i != '0)) begin
                cerr_o = cerr_i - CERR_ONE;
                if (cerr_i == CERR_ONE) begin
                    active_o  = 1'b0;
                    stalled_o = 1'b1;
                end
            end
        end
    end

    always_comb begin
        cause_o.ioc   = valid_i & ioc_i & ~active_o;
        cause_o.spd   = valid_i & active_i & spd_i & short_i & (outcome_i == OUT_ACK);
        cause_o.crcto = valid_i & crcto_o;
        cause_o.fatal = valid_i & stalled_o;
    end

endmodule

// File: rtl/usbst_frame_collect.sv
module usbst_frame_collect
    import usbst_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  cause_t new_i,
    input  logic   eof_i,
    output cause_t frame_o
);

    typedef struct packed {
        cause_t pend;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        frame_o = '0;
        if (eof_i) begin
            // same-cycle causes join the current frame end
            frame_o = st_q.pend | new_i;
            st_d.pend = '0;
        end else begin
            st_d.pend = st_q.pend | new_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_pend_empty_after_eof_R14: assert property (@(posedge clk) disable iff (!rst_n)
        eof_i |=> (st_q.pend == '0));

endmodule

// File: rtl/usbst_host_regs.sv
module usbst_host_regs
    import usbst_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  cause_t           set_i,
    input  logic             clr_we_i,
    input  logic [STS_W-1:0] clr_i,
    input  logic             ien_we_i,
    input  logic [IEN_W-1:0] ien_i,
    output logic [STS_W-1:0] sts_o,
    output logic [IEN_W-1:0] ien_o,
    output logic             irq_o
);

    typedef struct packed {
        logic [STS_W-1:0] sts;
        cause_t           src;
        logic [IEN_W-1:0] ien;
    } state_t;

    state_t st_d, st_q;
    logic   clr_int, clr_err;

    always_comb begin
        clr_int = clr_we_i & clr_i[0];
        clr_err = clr_we_i & clr_i[1];
        st_d    = st_q;
        st_d.src.ioc   = set_i.ioc   | (st_q.src.ioc   & ~clr_int);
        st_d.src.spd   = set_i.spd   | (st_q.src.spd   & ~clr_int);
        st_d.src.crcto = set_i.crcto | (st_q.src.crcto & ~clr_err);
        st_d.src.fatal = set_i.fatal | (st_q.src.fatal & ~clr_err);
        st_d.sts[0] = set_i.ioc | set_i.spd | (st_q.sts[0] & ~clr_int);
        st_d.sts[1] = set_i.crcto | set_i.fatal | (st_q.sts[1] & ~clr_err);
        if (ien_we_i) st_d.ien = ien_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sts_o = st_q.sts;
    assign ien_o = st_q.ien;
    assign irq_o = (st_q.src.ioc & st_q.ien[2]) | (st_q.src.spd & st_q.ien[3])
                 | (st_q.src.crcto & st_q.ien[0]) | st_q.src.fatal;

    assert_int_held_until_clear_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_o[0] && !(clr_we_i && clr_i[0])) |=> sts_o[0]);
    assert_err_held_until_clear_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_o[1] && !(clr_we_i && clr_i[1])) |=> sts_o[1]);
    assert_fatal_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
        set_i.fatal |=> (irq_o && sts_o[1]));

endmodule

// File: rtl/usb_xfer_status_unit.sv
module usb_xfer_status_unit
    import usbst_pkg::*;
#(
    parameter int LEN_W  = 11,
    parameter int CERR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              td_valid_i,
    input  logic              td_active_i,
    input  logic              td_ioc_i,
    input  logic              td_spd_i,
    input  logic [CERR_W-1:0] td_cerr_i,
    input  logic [2:0]        outcome_i,
    input  logic              short_pkt_i,
    input  logic [LEN_W-1:0]  xfer_len_i,
    input  logic              eof_i,
    input  logic              sts_clr_we_i,
    input  logic [1:0]        sts_clr_i,
    input  logic              ien_we_i,
    input  logic [3:0]        ien_i,
    output logic              upd_valid_o,
    output logic              upd_active_o,
    output logic              upd_stalled_o,
    output logic              upd_babble_o,
    output logic              upd_crcto_o,
    output logic              upd_buferr_o,
    output logic [CERR_W-1:0] upd_cerr_o,
    output logic [LEN_W-1:0]  upd_len_o,
    output logic [1:0]        sts_o,
    output logic [3:0]        ien_o,
    output logic              irq_o
);

    typedef struct packed {
        logic              valid;
        logic              active;
        logic              stalled;
        logic              babble;
        logic              crcto;
        logic              buferr;
        logic [CERR_W-1:0] cerr;
        logic [LEN_W-1:0]  len;
    } upd_t;

    upd_t   upd_d, upd_q, calc;
    cause_t new_cause, frame_cause;

    usbst_td_update #(.LEN_W(LEN_W), .CERR_W(CERR_W)) u_update (
        .valid_i  (td_valid_i),
        .active_i (td_active_i),
        .ioc_i    (td_ioc_i),
        .spd_i    (td_spd_i),
        .cerr_i   (td_cerr_i),
        .outcome_i(outcome_i),
        .short_i  (short_pkt_i),
        .len_i    (xfer_len_i),
        .active_o (calc.active),
        .stalled_o(calc.stalled),
        .babble_o (calc.babble),
        .crcto_o  (calc.crcto),
        .buferr_o (calc.buferr),
        .cerr_o   (calc.cerr),
        .len_o    (calc.len),
        .cause_o  (new_cause)
    );
    assign calc.valid = td_valid_i;

    usbst_frame_collect u_collect (
        .clk    (clk),
        .rst_n  (rst_n),
        .new_i  (new_cause),
        .eof_i  (eof_i),
        .frame_o(frame_cause)
    );

    usbst_host_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (frame_cause),
        .clr_we_i(sts_clr_we_i),
        .clr_i   (sts_clr_i),
        .ien_we_i(ien_we_i),
        .ien_i   (ien_i),
        .sts_o   (sts_o),
        .ien_o   (ien_o),
        .irq_o   (irq_o)
    );

    always_comb begin
        upd_d = calc.valid ? calc : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) upd_q <= '0;
        else        upd_q <= upd_d;
    end

    assign upd_valid_o   = upd_q.valid;
    assign upd_active_o  = upd_q.active;
    assign upd_stalled_o = upd_q.stalled;
    assign upd_babble_o  = upd_q.babble;
    assign upd_crcto_o   = upd_q.crcto;
    assign upd_buferr_o  = upd_q.buferr;
    assign upd_cerr_o    = upd_q.cerr;
    assign upd_len_o     = upd_q.len;

    assert_stall_clears_active_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid_o && upd_stalled_o) |-> !upd_active_o);
    assert_babble_keeps_cerr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (td_valid_i && td_active_i && outcome_i == OUT_BABBLE)
        |=> (upd_babble_o && upd_cerr_o == $past(td_cerr_i)));
    assert_zero_cerr_retries_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (td_valid_i && td_active_i && td_cerr_i == '0
         && (outcome_i == OUT_CRCTO || outcome_i == OUT_BUFERR))
        |=> (upd_active_o && upd_cerr_o == '0 && !upd_stalled_o));
    assert_int_rises_at_eof_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_o[0]) |-> $past(eof_i));

endmodule

// File: tb/usb_xfer_status_unit_tb.sv
module usb_xfer_status_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        td_valid_i = 0, td_active_i = 0, td_ioc_i = 0, td_spd_i = 0;
    logic [1:0]  td_cerr_i = 0;
    logic [2:0]  outcome_i = 0;
    logic        short_pkt_i = 0;
    logic [10:0] xfer_len_i = 0;
    logic        eof_i = 0, sts_clr_we_i = 0, ien_we_i = 0;
    logic [1:0]  sts_clr_i = 0;
    logic [3:0]  ien_i = 0;
    logic        upd_valid_o, upd_active_o, upd_stalled_o, upd_babble_o;
    logic        upd_crcto_o, upd_buferr_o, irq_o;
    logic [1:0]  upd_cerr_o, sts_o;
    logic [10:0] upd_len_o;
    logic [3:0]  ien_o;

    int n_checks = 0;
    int n_fails  = 0;

    typedef struct {
        logic        active, stalled, babble, crcto, buferr;
        logic [1:0]  cerr;
        logic [10:0] len;
        string       req;
    } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;

    usb_xfer_status_unit u_dut (.*);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // bench model of the descriptor update, from the requirements
    function automatic exp_t model(input logic act, input logic [1:0] ce,
                                   input logic [2:0] oc, input logic [10:0] ln,
                                   input string req);
        exp_t e;
        e = '{active: act, stalled: 0, babble: 0, crcto: 0, buferr: 0,
              cerr: ce, len: 0, req: req};
        if (act) begin
            if (oc == 0) begin e.active = 0; e.len = ln; end
            else if (oc == 2) begin e.active = 0; e.stalled = 1; end
            else if (oc == 3) begin e.active = 0; e.stalled = 1; e.babble = 1; end
            else if (oc == 4 || oc == 5) begin
                if (oc == 4) e.crcto = 1; else e.buferr = 1;
                if (ce != 0) begin
                    e.cerr = ce - 2'd1;
                    if (ce == 2'd1) begin e.active = 0; e.stalled = 1; end
                end
            end
        end
        return e;
    endfunction

    task automatic xact(input logic act, input logic ioc, input logic spd,
                        input logic [1:0] ce, input logic [2:0] oc, input logic sh,
                        input logic [10:0] ln, input logic eof, input string req);
        @(negedge clk);
        td_valid_i = 1; td_active_i = act; td_ioc_i = ioc; td_spd_i = spd;
        td_cerr_i = ce; outcome_i = oc; short_pkt_i = sh; xfer_len_i = ln; eof_i = eof;
        sb.push_back(model(act, ce, oc, ln, req));
        @(negedge clk);
        td_valid_i = 0; eof_i = 0;
    endtask

    task automatic frame_end();
        @(negedge clk); eof_i = 1;
        @(negedge clk); eof_i = 0;
    endtask

    task automatic set_ien(input logic [3:0] v);
        @(negedge clk); ien_we_i = 1; ien_i = v;
        @(negedge clk); ien_we_i = 0;
    endtask

    task automatic clear_sts(input logic [1:0] m);
        @(negedge clk); sts_clr_we_i = 1; sts_clr_i = m;
        @(negedge clk); sts_clr_we_i = 0; sts_clr_i = 0;
    endtask

    // monitor: compare each update against the scoreboard head
    always @(posedge clk) begin
        #1;
        if (rst_n && upd_valid_o) begin
            if (sb.size() == 0) check(0, "R2", 1, 0);
            else begin
                exp_t e;
                e = sb.pop_front();
                check(upd_active_o == e.active, e.req, upd_active_o, e.active);
                check(upd_stalled_o == e.stalled, e.req, upd_stalled_o, e.stalled);
                check(upd_babble_o == e.babble, e.req, upd_babble_o, e.babble);
                check({upd_crcto_o, upd_buferr_o} == {e.crcto, e.buferr}, e.req,
                      {upd_crcto_o, upd_buferr_o}, {e.crcto, e.buferr});
                check(upd_cerr_o == e.cerr, e.req, upd_cerr_o, e.cerr);
                check(upd_len_o == e.len, e.req, upd_len_o, e.len);
            end
        end
    end

    initial begin
        #(200000 * 4);
        check(0, "watchdog", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check(sts_o == 0 && ien_o == 0, "R1", {sts_o, ien_o}, 0);
        check(irq_o == 0 && upd_valid_o == 0, "R1", {irq_o, upd_valid_o}, 0);

        // R2 ACK with completion flag; R7 only at frame end; R12 gating
        xact(1, 1, 0, 3, 0, 0, 11'd37, 0, "R2");
        check(sts_o == 0, "R7", sts_o, 0);
        frame_end();
        check(sts_o == 2'b01, "R7", sts_o, 1);
        check(irq_o == 0, "R12", irq_o, 0);
        set_ien(4'b0100);
        check(irq_o == 1, "R12", irq_o, 1);
        clear_sts(2'b01);
        check(sts_o == 0 && irq_o == 0, "R13", {sts_o, irq_o}, 0);

        // R3 inactive descriptor, still completes R7
        xact(0, 1, 0, 2, 2, 0, 11'd5, 0, "R3");
        frame_end();
        check(sts_o == 2'b01, "R7", sts_o, 1);
        clear_sts(2'b01);

        // R3 NAK and unused code change nothing
        xact(1, 1, 0, 2, 1, 0, 11'd9, 0, "R3");
        xact(1, 0, 0, 1, 7, 0, 11'd9, 0, "R3");
        frame_end();
        check(sts_o == 0 && irq_o == 0, "R3", {sts_o, irq_o}, 0);

        // R4 STALL with completion, same-cycle frame end R14, R8, R11
        set_ien(4'b0000);
        xact(1, 1, 0, 2, 2, 0, 11'd0, 1, "R4");
        check(sts_o == 2'b11, "R14", sts_o, 3);
        check(irq_o == 1, "R11", irq_o, 1);
        clear_sts(2'b01);
        check(sts_o == 2'b10 && irq_o == 1, "R8", {sts_o, irq_o}, 5);
        clear_sts(2'b10);
        check(sts_o == 0 && irq_o == 0, "R13", {sts_o, irq_o}, 0);

        // R5 babble
        xact(1, 0, 0, 3, 3, 0, 11'd0, 0, "R5");
        frame_end();
        check(sts_o == 2'b10 && irq_o == 1, "R11", {sts_o, irq_o}, 5);
        clear_sts(2'b10);

        // R6 counter 2 -> 1 stays active; R10 enable gating
        xact(1, 0, 0, 2, 4, 0, 11'd0, 0, "R6");
        frame_end();
        check(sts_o == 2'b10 && irq_o == 0, "R10", {sts_o, irq_o}, 4);
        set_ien(4'b0001);
        check(irq_o == 1, "R10", irq_o, 1);
        clear_sts(2'b10);
        check(irq_o == 0, "R13", irq_o, 0);

        // R6 counter 1 -> 0 stalls, irq regardless of enables
        set_ien(4'b0000);
        xact(1, 0, 0, 1, 4, 0, 11'd0, 0, "R6");
        frame_end();
        check(irq_o == 1, "R11", irq_o, 1);
        clear_sts(2'b10);

        // R6 zero counter, buffer error decrement
        xact(1, 0, 0, 0, 4, 0, 11'd0, 0, "R6");
        xact(1, 0, 0, 3, 5, 0, 11'd0, 0, "R6");
        frame_end();
        check(sts_o == 2'b10 && irq_o == 0, "R10", {sts_o, irq_o}, 4);
        clear_sts(2'b10);

        // R9 short packet
        xact(1, 0, 1, 3, 0, 1, 11'd12, 0, "R9");
        frame_end();
        check(sts_o == 2'b01 && irq_o == 0, "R9", {sts_o, irq_o}, 2);
        set_ien(4'b1000);
        check(irq_o == 1, "R9", irq_o, 1);
        clear_sts(2'b01);
        xact(1, 0, 0, 3, 0, 1, 11'd12, 0, "R9");
        frame_end();
        check(sts_o == 0, "R9", sts_o, 0);

        // R13 set wins over same-cycle clear
        xact(1, 1, 0, 3, 0, 0, 11'd1, 0, "R2");
        frame_end();
        xact(1, 1, 0, 3, 0, 0, 11'd2, 0, "R2");
        @(negedge clk);
        eof_i = 1; sts_clr_we_i = 1; sts_clr_i = 2'b01;
        @(negedge clk);
        eof_i = 0; sts_clr_we_i = 0; sts_clr_i = 0;
        check(sts_o[0] == 1, "R13", sts_o[0], 1);

        repeat (3) @(negedge clk);
        check(sb.size() == 0, "R2", sb.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule